// File: doc/BRIEF.md
# Interrupt Status and Vector Unit

This block holds the event flags of a bus master controller and turns them into one interrupt line and two DMA request lines (receive and transmit). The transfer logic raises flags with one-cycle set pulses; software sees the flags through a small 16-bit register port. Through that port it can enable interrupt sources, clear flags, hand the ready events of either direction to a DMA engine, and force flags for a self-test.

A vector register serves the interrupt handler. Reading it returns the lowest-numbered flag that is both pending and enabled, coded as its bit index plus one. The same read clears that one flag, so a handler can drain every source by reading the vector until it returns zero. When DMA is enabled for a direction, that direction's ready interrupt is masked at once, so the DMA engine and the processor do not both service the same event.

Top module: `intr_status_unit`

## Requirements
- R1: `irqOut` is high in the cycle after any stored status bit and the matching interrupt-enable bit are both 1, and low in the cycle after no such pair exists.
- R2: A read of the vector register (address 3) returns 0 when no enabled flag is pending. Otherwise it returns the bit index plus one of the lowest pending enabled flag and clears only that status bit.
- R3: `rxDmaReq` follows status bit 3 (receive ready) only while DMA-enable bit 15 is 1. `txDmaReq` follows status bit 4 (transmit ready) only while DMA-enable bit 7 is 1. Both lag the registers by one cycle.
- R4: A write to the DMA-enable register (address 2) stores only bits 15 and 7. A 1 written to bit 15 clears interrupt-enable bit 3, and a 1 written to bit 7 clears interrupt-enable bit 4.
- R5: A write to the status register (address 0) clears each status bit that is 1 in both the written value and 0x0027. It has no effect on any other bit, and in particular none on bits 3 and 4.
- R6: A write to the interrupt-enable register (address 1) stores the value ANDed with 0x3F when the newer variant is selected (the default) and with 0x1F for the older variant.
- R7: In the newer variant, a write to the self-test register (address 4) with bit 11 set makes status bits 5:0 all ones. Address 4 reads as 0.
- R8: A status read returns the live `busBusy` input in bit 12. Bit 12 is never stored, and a set pulse on bit 12 has no effect.
- R9: When a set pulse and a software clear (status write or vector read) hit the same bit in the same cycle, the bit ends up set.
- R10: Reset clears the status, interrupt-enable and DMA-enable registers and drives all three request outputs low.
- R11: A read strobe loads `regRdData` at the next clock edge, and `regRdData` holds that value until the next read. Unmapped addresses read 0 and ignore writes. A write strobe takes priority over a read strobe asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data, registered |
| setFlags | input | 16 | One-cycle set pulses from the transfer logic |
| busBusy | input | 1 | Live bus-busy indication |
| irqOut | output | 1 | Interrupt request |
| rxDmaReq | output | 1 | Receive DMA request |
| txDmaReq | output | 1 | Transmit DMA request |

## Verification
The bench drains several pending flags through repeated vector reads and checks the order and the final zero. A design that picked the highest bit, or cleared more than one bit per read, would return the wrong codes or skip sources. It writes all ones to the status register while bits 3 and 4 are set, which catches a clear mask that also reaches the ready flags. It fires a set pulse in the same cycle as a clear of that bit, which a design where the clear wins would lose. It also writes DMA-enable bits over a full interrupt-enable mask, and a design that failed to mask the ready interrupts would keep `irqOut` high. Randomized accesses with random set pulses then compare every output against a reference model built from the requirements.

// File: rtl/intr_status_pkg.sv
package intr_status_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_STATUS = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_ENABLE = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_DMA    = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_VECTOR = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_TEST   = 3'd4;

  typedef enum logic [2:0] {
    SEL_STATUS = 3'd0,
    SEL_ENABLE = 3'd1,
    SEL_DMA    = 3'd2,
    SEL_VECTOR = 3'd3,
    SEL_ZERO   = 3'd4
  } rd_sel_e;

  typedef struct packed {
    logic    wrStatus;
    logic    wrEnable;
    logic    wrDma;
    logic    wrTest;
    logic    rdVector;
    logic    rdAny;
    rd_sel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/intr_prio_enc.sv
module intr_prio_enc #(
  parameter int WIDTH = 16,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] reqVec,
  output logic             anyReq,
  output logic [IDX_W-1:0] lowIdx
);
  // Scan from the top down so the last hit is the lowest index.
  always_comb begin
    anyReq = 1'b0;
    lowIdx = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (reqVec[i]) begin
        anyReq = 1'b1;
        lowIdx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/intr_status_ctrl.sv
module intr_status_ctrl
  import intr_status_pkg::*;
(
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  output strobe_t           strb
);
  logic rdOk;

  // A write in the same cycle suppresses the read (R11).
  assign rdOk = regRdEn && !regWrEn;

  always_comb begin
    strb          = '0;
    strb.wrStatus = regWrEn && (regAddr == ADDR_STATUS);
    strb.wrEnable = regWrEn && (regAddr == ADDR_ENABLE);
    strb.wrDma    = regWrEn && (regAddr == ADDR_DMA);
    strb.wrTest   = regWrEn && (regAddr == ADDR_TEST);
    strb.rdVector = rdOk && (regAddr == ADDR_VECTOR);
    strb.rdAny    = rdOk;
    unique case (regAddr)
      ADDR_STATUS: strb.rdSel = SEL_STATUS;
      ADDR_ENABLE: strb.rdSel = SEL_ENABLE;
      ADDR_DMA:    strb.rdSel = SEL_DMA;
      ADDR_VECTOR: strb.rdSel = SEL_VECTOR;
      default:     strb.rdSel = SEL_ZERO;
    endcase
  end
endmodule

// File: rtl/intr_status_dp.sv
module intr_status_dp
  import intr_status_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter bit NEWER_VAR  = 1'b1,
  parameter int RX_RDY_BIT = 3,
  parameter int TX_RDY_BIT = 4,
  parameter int RX_DMA_BIT = 15,
  parameter int TX_DMA_BIT = 7,
  parameter int BUSY_BIT   = 12,
  parameter int TEST_BIT   = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] setFlags,
  input  logic              busBusy,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut,
  output logic              rxDmaReq,
  output logic              txDmaReq
);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [DATA_W-1:0] ONE        = DATA_W'(1);
  localparam logic [DATA_W-1:0] STORE_MASK = ~(ONE << BUSY_BIT);
  localparam logic [DATA_W-1:0] EN_MASK    = NEWER_VAR ? DATA_W'(6'h3F) : DATA_W'(5'h1F);
  localparam logic [DATA_W-1:0] W1C_MASK   = DATA_W'(6'h27);
  localparam logic [DATA_W-1:0] FORCE_MASK = DATA_W'(6'h3F);
  localparam logic [DATA_W-1:0] DMA_MASK   = (ONE << RX_DMA_BIT) | (ONE << TX_DMA_BIT);
  localparam logic [DATA_W-1:0] RDY_MASK   = (ONE << RX_RDY_BIT) | (ONE << TX_RDY_BIT);

  logic [DATA_W-1:0] status, enable, dmaEn;
  logic [DATA_W-1:0] statusNext, enableNext, dmaNext;
  logic [DATA_W-1:0] pending, vecClr, swClr, forceSet, vecCode, rdMux;
  logic              vecFound;
  logic [IDX_W-1:0]  vecIdx;

  assign pending = status & enable;

  intr_prio_enc #(.WIDTH(DATA_W)) prioEnc_i (
    .reqVec(pending),
    .anyReq(vecFound),
    .lowIdx(vecIdx)
  );

  assign vecCode = vecFound ? (DATA_W'(vecIdx) + ONE) : '0;
  assign vecClr  = (strb.rdVector && vecFound) ? (ONE << vecIdx) : '0;
  assign swClr   = strb.wrStatus ? (wrData & W1C_MASK) : '0;

  generate
    if (NEWER_VAR) begin : g_force
      assign forceSet = (strb.wrTest && wrData[TEST_BIT]) ? FORCE_MASK : '0;
    end else begin : g_noforce
      assign forceSet = '0;
    end
  endgenerate

  // Set sources are ORed in after the clears so a set always wins (R9).
  assign statusNext = ((status & ~(vecClr | swClr)) | setFlags | forceSet) & STORE_MASK;

  always_comb begin
    enableNext = enable;
    dmaNext    = dmaEn;
    if (strb.wrEnable) enableNext = wrData & EN_MASK;
    if (strb.wrDma) begin
      dmaNext = wrData & DMA_MASK;
      if (wrData[RX_DMA_BIT]) enableNext[RX_RDY_BIT] = 1'b0;
      if (wrData[TX_DMA_BIT]) enableNext[TX_RDY_BIT] = 1'b0;
    end
  end

  always_comb begin
    unique case (strb.rdSel)
      SEL_STATUS: rdMux = status | (DATA_W'(busBusy) << BUSY_BIT);
      SEL_ENABLE: rdMux = enable;
      SEL_DMA:    rdMux = dmaEn;
      SEL_VECTOR: rdMux = vecCode;
      default:    rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      status   <= '0;
      enable   <= '0;
      dmaEn    <= '0;
      rdData   <= '0;
      irqOut   <= 1'b0;
      rxDmaReq <= 1'b0;
      txDmaReq <= 1'b0;
    end else begin
      status   <= statusNext;
      enable   <= enableNext;
      dmaEn    <= dmaNext;
      if (strb.rdAny) rdData <= rdMux;
      irqOut   <= |pending;
      rxDmaReq <= dmaEn[RX_DMA_BIT] & status[RX_RDY_BIT];
      txDmaReq <= dmaEn[TX_DMA_BIT] & status[TX_RDY_BIT];
    end
  end

  assert_rx_gate_R3: assert property (@(posedge clk) disable iff (!rstN)
    rxDmaReq |-> $past(dmaEn[RX_DMA_BIT]));
  assert_tx_gate_R3: assert property (@(posedge clk) disable iff (!rstN)
    txDmaReq |-> $past(dmaEn[TX_DMA_BIT]));
  assert_dma_masks_ie_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrDma && wrData[RX_DMA_BIT]) |=> !enable[RX_RDY_BIT]);
  assert_rdy_kept_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrStatus |=> ((status & $past(status) & RDY_MASK) == ($past(status) & RDY_MASK)));
  assert_vec_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdVector |=> ($countones($past(status) & ~status) <= 1));
  assert_busy_unstored_R8: assert property (@(posedge clk) disable iff (!rstN)
    !status[BUSY_BIT]);
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((setFlags & STORE_MASK) != '0) |=>
      ((status & $past(setFlags & STORE_MASK)) == $past(setFlags & STORE_MASK)));

  generate
    if (NEWER_VAR) begin : g_force_chk
      assert_selftest_R7: assert property (@(posedge clk) disable iff (!rstN)
        (strb.wrTest && wrData[TEST_BIT]) |=> ((status & FORCE_MASK) == FORCE_MASK));
    end
  endgenerate
endmodule

// File: rtl/intr_status_unit.sv
module intr_status_unit
  import intr_status_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter bit NEWER_VAR = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [DATA_W-1:0] setFlags,
  input  logic              busBusy,
  output logic              irqOut,
  output logic              rxDmaReq,
  output logic              txDmaReq
);
  strobe_t strb;

  intr_status_ctrl ctrl_i (
    .regWrEn(regWrEn),
    .regRdEn(regRdEn),
    .regAddr(regAddr),
    .strb(strb)
  );

  intr_status_dp #(.DATA_W(DATA_W), .NEWER_VAR(NEWER_VAR)) dp_i (
    .clk(clk),
    .rstN(rstN),
    .strb(strb),
    .wrData(regWrData),
    .setFlags(setFlags),
    .busBusy(busBusy),
    .rdData(regRdData),
    .irqOut(irqOut),
    .rxDmaReq(rxDmaReq),
    .txDmaReq(txDmaReq)
  );

  assert_no_rd_on_wr_R11: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regRdEn) |=> $stable(regRdData));
endmodule

// File: tb/intr_status_unit_tb.sv
module intr_status_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [15:0] regWrData = '0, regRdData;
  logic [15:0] setFlags = '0;
  logic        busBusy = 1'b0;
  logic        irqOut, rxDmaReq, txDmaReq;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // Reference state
  logic [15:0] mStat = '0, mEn = '0, mDma = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_status_unit dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .setFlags(setFlags), .busBusy(busBusy), .irqOut(irqOut),
    .rxDmaReq(rxDmaReq), .txDmaReq(txDmaReq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] vecOf(input logic [15:0] s, input logic [15:0] e);
    for (int i = 0; i < 16; i++) if (s[i] & e[i]) return 16'(i + 1);
    return 16'd0;
  endfunction

  // One access; outputs are compared one edge later.
  task automatic step(input bit wr, input bit rd, input logic [2:0] a,
                      input logic [15:0] wd, input logic [15:0] st,
                      input bit busy, input string tag);
    logic [15:0] expRd, clr, setv, code;
    logic expIrq, expRx, expTx;
    bit doRd;
    regWrEn = wr; regRdEn = rd; regAddr = a; regWrData = wd;
    setFlags = st; busBusy = busy;
    doRd   = rd && !wr;
    expIrq = |(mStat & mEn);
    expRx  = mDma[15] & mStat[3];
    expTx  = mDma[7] & mStat[4];
    code   = vecOf(mStat, mEn);
    case (a)
      3'd0: expRd = mStat | (16'(busy) << 12);
      3'd1: expRd = mEn;
      3'd2: expRd = mDma;
      3'd3: expRd = code;
      default: expRd = 16'd0;
    endcase
    clr  = '0;
    setv = st & 16'hEFFF;
    if (wr && a == 3'd0) clr = wd & 16'h0027;
    if (doRd && a == 3'd3 && code != 0) clr = 16'd1 << (code - 1);
    if (wr && a == 3'd4 && wd[11]) setv |= 16'h003F;
    mStat = (mStat & ~clr) | setv;
    if (wr && a == 3'd1) mEn = wd & 16'h003F;
    if (wr && a == 3'd2) begin
      mDma = wd & 16'h8080;
      if (wd[15]) mEn[3] = 1'b0;
      if (wd[7])  mEn[4] = 1'b0;
    end
    @(negedge clk);
    chk("R1 irq", 16'(irqOut), 16'(expIrq));
    chk("R3 rxDma", 16'(rxDmaReq), 16'(expRx));
    chk("R3 txDma", 16'(txDmaReq), 16'(expTx));
    if (doRd) chk(tag, regRdData, expRd);
    regWrEn = 1'b0; regRdEn = 1'b0; setFlags = '0;
  endtask

  task automatic idle();
    step(0, 0, 3'd0, 16'd0, 16'd0, 0, "idle");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R10: reset state
    chk("R10 irq", 16'(irqOut), 16'd0);
    chk("R10 rx", 16'(rxDmaReq), 16'd0);
    step(0, 1, 3'd0, 0, 0, 0, "R10 status zero");
    step(0, 1, 3'd1, 0, 0, 0, "R10 enable zero");
    step(0, 1, 3'd2, 0, 0, 0, "R10 dma zero");
    // R6: enable width
    step(1, 0, 3'd1, 16'hFFFF, 0, 0, "R6");
    step(0, 1, 3'd1, 0, 0, 0, "R6 enable mask 0x3F");
    // R1/R2: drain flags 1 and 5 via vector, then flag 0 pending but disabled
    step(1, 0, 3'd1, 16'h0022, 16'h0023, 0, "R2");
    idle(); idle();
    step(0, 1, 3'd3, 0, 0, 0, "R2 vector first");
    step(0, 1, 3'd3, 0, 0, 0, "R2 vector second");
    step(0, 1, 3'd3, 0, 0, 0, "R2 vector empty");
    idle();
    step(0, 1, 3'd0, 0, 0, 0, "R2 status after drain");
    // R5: W1C with all ones while ready flags set
    step(0, 0, 3'd0, 0, 16'h003F, 0, "R5");
    step(1, 0, 3'd0, 16'hFFFF, 0, 0, "R5");
    step(0, 1, 3'd0, 0, 0, 0, "R5 only 0x27 cleared");
    // R4/R3: dma enable masks ready interrupts
    step(1, 0, 3'd1, 16'h003F, 0, 0, "R4");
    step(1, 0, 3'd2, 16'hFFFF, 0, 0, "R4");
    step(0, 1, 3'd2, 0, 0, 0, "R4 dma kept bits");
    step(0, 1, 3'd1, 0, 0, 0, "R4 ready ie cleared");
    idle(); idle();
    // R8: busy live, bit 12 pulse ignored
    step(0, 0, 3'd0, 0, 16'h1000, 0, "R8");
    step(0, 1, 3'd0, 0, 0, 1, "R8 busy high");
    step(0, 1, 3'd0, 0, 0, 0, "R8 busy low");
    // R9: set wins over clear
    step(1, 0, 3'd0, 16'h0001, 16'h0001, 0, "R9");
    step(0, 1, 3'd0, 0, 0, 0, "R9 set survives");
    // R7: self-test force
    step(1, 0, 3'd0, 16'h0027, 0, 0, "R7");
    step(1, 0, 3'd4, 16'h0800, 0, 0, "R7");
    step(0, 1, 3'd0, 0, 0, 0, "R7 forced bits");
    step(0, 1, 3'd4, 0, 0, 0, "R7 test reads zero");
    // R11: unmapped, write priority
    step(1, 0, 3'd6, 16'hFFFF, 0, 0, "R11");
    step(0, 1, 3'd6, 0, 0, 0, "R11 unmapped zero");
    step(1, 1, 3'd1, 16'h0005, 0, 0, "R11");
    step(0, 1, 3'd1, 0, 0, 0, "R11 write won");
    // Random phase
    for (int n = 0; n < 600; n++) begin
      logic [2:0] a;
      bit w, r;
      a = 3'($urandom_range(0, 5));
      w = ($urandom_range(0, 2) == 0);
      r = !w && ($urandom_range(0, 1) == 1);
      step(w, r, a, 16'($urandom), 16'($urandom & $urandom & $urandom),
           $urandom_range(0, 1) == 1, "R2 R5 R6 random read");
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule